// File: doc/BRIEF.md
# Multiplexed Adder Arithmetic Unit with Status Flags

This block performs every arithmetic operation of a small datapath with one shared n-bit ripple adder. A 5-bit function code steers three selectors in front of the adder. One picks the first operand from A or its inverse. One picks the second operand from B, its inverse, all zeros or all ones. One picks the carry input from the stored carry flag, its inverse, a constant 0 or a constant 1. The operation itself is therefore only a choice of adder inputs.

The block presents the adder sum as the result, together with a result-write enable for the surrounding register file. It also presents next values and update enables for four status flags: zero, sign, carry and overflow. A small registered flag file captures these on the clock edge whenever a valid operation is strobed. The stored carry flag is fed back to the carry selector. This lets add-with-carry and subtract-with-borrow chain across words.

Top module: `arith_unit`

## Requirements
- R1: Code 5'b00000 (add with carry) yields result = A + B + C, where C is the stored carry flag. The result-write enable is high and all four flag enables are high.
- R2: Code 5'b00001 (subtract with borrow) yields result = A + (~B) + (~C) modulo 2^WIDTH. The write enable and all four flag enables are high.
- R3: Code 5'b00010 (compare) evaluates A + (~B) + 1 and updates all four flags. The result-write enable stays low.
- R4: Code 5'b00011 (increment) yields A + 1 and code 5'b00100 (decrement) yields A + all-ones. Both raise the write enable and the zero/sign enables, keep the carry/overflow enables low, and leave the stored carry and overflow flags unchanged.
- R5: Code 5'b00101 yields (~A) + 1, code 5'b00110 yields A, and code 5'b00111 yields ~A. Each raises the write enable and all four flag enables.
- R6: The next sign flag equals the result's most significant bit. The next zero flag is 1 exactly when every result bit is 0.
- R7: The next carry flag is the adder's carry-out. The next overflow flag is 1 exactly when the two's-complement sum of the selected operands plus carry-in falls outside the signed WIDTH-bit range.
- R8: Codes 5'b01000 through 5'b11111 are reserved. They drive the write enable and every flag enable low, and the stored flags do not change.
- R9: A synchronous active-high reset clears all four stored flags. When op_valid is low, the write enable and all flag enables are low and the stored flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag file |
| op_valid | input | 1 | Strobe: an operation is issued this cycle |
| func_code | input | 5 | Function code selecting the operation |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| result | output | WIDTH | Adder sum |
| result_we | output | 1 | Result-write enable |
| zero_nxt | output | 1 | Next zero flag |
| sign_nxt | output | 1 | Next sign flag |
| carry_nxt | output | 1 | Next carry/borrow flag |
| ovf_nxt | output | 1 | Next overflow flag |
| zero_en | output | 1 | Zero flag update enable |
| sign_en | output | 1 | Sign flag update enable |
| carry_en | output | 1 | Carry flag update enable |
| ovf_en | output | 1 | Overflow flag update enable |
| zero_q | output | 1 | Stored zero flag |
| sign_q | output | 1 | Stored sign flag |
| carry_q | output | 1 | Stored carry flag, also fed back as carry-in source |
| ovf_q | output | 1 | Stored overflow flag |

## Verification
The bench runs a 4-bit instance through every defined code, every A and B value, and both stored-carry states. Each stored carry state is set beforehand by a compare. This separates the selector choices from one another: a wrong inverse, a wrong constant or a wrong carry source each changes some sum or flag. Sums that cross 7/8 and 15/0 separate signed overflow from unsigned carry. Reserved codes, an idle strobe and a mid-run reset are applied after the flags have been left non-zero, so any spurious update or missing clear shows at the stored-flag outputs.

// File: rtl/arith_pkg.sv
package arith_pkg;

  localparam logic [4:0] FN_ADC  = 5'd0;
  localparam logic [4:0] FN_SBB  = 5'd1;
  localparam logic [4:0] FN_CMP  = 5'd2;
  localparam logic [4:0] FN_INC  = 5'd3;
  localparam logic [4:0] FN_DEC  = 5'd4;
  localparam logic [4:0] FN_NEG  = 5'd5;
  localparam logic [4:0] FN_PASS = 5'd6;
  localparam logic [4:0] FN_CPL  = 5'd7;

  typedef enum logic {OP1_A, OP1_NA} op1_sel_e;
  typedef enum logic [1:0] {OP2_B, OP2_NB, OP2_ZERO, OP2_ONES} op2_sel_e;
  typedef enum logic [1:0] {CIN_FLAG, CIN_ZERO, CIN_ONE, CIN_NFLAG} cin_sel_e;

  typedef struct packed {
    op1_sel_e op1;
    op2_sel_e op2;
    cin_sel_e cin;
    logic     wr;
    logic     upd_zs;
    logic     upd_cv;
  } ctrl_t;

  function automatic ctrl_t decode_fn(input logic [4:0] fn);
    ctrl_t c;
    c = '{op1: OP1_A, op2: OP2_ZERO, cin: CIN_ZERO, wr: 1'b0, upd_zs: 1'b0, upd_cv: 1'b0};
    case (fn)
      FN_ADC:  c = '{op1: OP1_A,  op2: OP2_B,    cin: CIN_FLAG,  wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b1};
      FN_SBB:  c = '{op1: OP1_A,  op2: OP2_NB,   cin: CIN_NFLAG, wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b1};
      FN_CMP:  c = '{op1: OP1_A,  op2: OP2_NB,   cin: CIN_ONE,   wr: 1'b0, upd_zs: 1'b1, upd_cv: 1'b1};
      FN_INC:  c = '{op1: OP1_A,  op2: OP2_ZERO, cin: CIN_ONE,   wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b0};
      FN_DEC:  c = '{op1: OP1_A,  op2: OP2_ONES, cin: CIN_ZERO,  wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b0};
      FN_NEG:  c = '{op1: OP1_NA, op2: OP2_ZERO, cin: CIN_ONE,   wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b1};
      FN_PASS: c = '{op1: OP1_A,  op2: OP2_ZERO, cin: CIN_ZERO,  wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b1};
      FN_CPL:  c = '{op1: OP1_NA, op2: OP2_ZERO, cin: CIN_ZERO,  wr: 1'b1, upd_zs: 1'b1, upd_cv: 1'b1};
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/arith_decode.sv
module arith_decode
  import arith_pkg::*;
(
  input  logic       op_valid,
  input  logic [4:0] func_code,
  output op1_sel_e   op1_sel,
  output op2_sel_e   op2_sel,
  output cin_sel_e   cin_sel,
  output logic       wr_o,
  output logic       upd_zs_o,
  output logic       upd_cv_o
);

  ctrl_t raw;

  always_comb begin
    raw      = decode_fn(func_code);
    op1_sel  = raw.op1;
    op2_sel  = raw.op2;
    cin_sel  = raw.cin;
    wr_o     = raw.wr & op_valid;
    upd_zs_o = raw.upd_zs & op_valid;
    upd_cv_o = raw.upd_cv & op_valid;
  end

  // R8: reserved codes leave every enable low
  always_comb begin
    if (func_code[4:3] != 2'b00) begin
      assert_reserved_idle_R8: assert (!wr_o && !upd_zs_o && !upd_cv_o);
    end
  end

endmodule

// File: rtl/arith_operand_mux.sv
module arith_operand_mux
  import arith_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  op1_sel_e           op1_sel,
  input  op2_sel_e           op2_sel,
  input  cin_sel_e           cin_sel,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               carry_flag_i,
  output logic [WIDTH-1:0]   op1_o,
  output logic [WIDTH-1:0]   op2_o,
  output logic               cin_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  always_comb begin
    case (op1_sel)
      OP1_NA:  op1_o = ~a_i;
      default: op1_o = a_i;
    endcase
  end

  always_comb begin
    case (op2_sel)
      OP2_B:    op2_o = b_i;
      OP2_NB:   op2_o = ~b_i;
      OP2_ONES: op2_o = ALL_ONES;
      default:  op2_o = '0;
    endcase
  end

  always_comb begin
    case (cin_sel)
      CIN_FLAG:  cin_o = carry_flag_i;
      CIN_ONE:   cin_o = 1'b1;
      CIN_NFLAG: cin_o = ~carry_flag_i;
      default:   cin_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/arith_adder.sv
module arith_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op1_i,
  input  logic [WIDTH-1:0] op2_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  function automatic logic cell_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic cell_carry(input logic gen, input logic prop, input logic c);
    return gen | (prop & c);
  endfunction

  logic [WIDTH:0] cy;
  assign cy[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic gen_w;
    logic prop_w;
    assign gen_w    = op1_i[i] & op2_i[i];
    assign prop_w   = op1_i[i] | op2_i[i];
    assign sum_o[i] = cell_sum(op1_i[i], op2_i[i], cy[i]);
    assign cy[i+1]  = cell_carry(gen_w, prop_w, cy[i]);
  end

  // carry out of the sign position vs. carry into it
  logic carry_into_msb;
  assign carry_into_msb = cy[MSB];
  assign cout_o         = cy[WIDTH];
  assign ovf_o          = cy[WIDTH] ^ carry_into_msb;

endmodule

// File: rtl/arith_flag_file.sv
module arith_flag_file (
  input  logic clk,
  input  logic rst,
  input  logic zs_en_i,
  input  logic cv_en_i,
  input  logic zero_d,
  input  logic sign_d,
  input  logic carry_d,
  input  logic ovf_d,
  output logic zero_q,
  output logic sign_q,
  output logic carry_q,
  output logic ovf_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q  <= 1'b0;
      sign_q  <= 1'b0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (zs_en_i) begin
        zero_q <= zero_d;
        sign_q <= sign_d;
      end
      if (cv_en_i) begin
        carry_q <= carry_d;
        ovf_q   <= ovf_d;
      end
    end
  end

  // R9: reset clears every stored flag
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!zero_q && !sign_q && !carry_q && !ovf_q));

  // R4: carry/overflow hold while their enable is low
  assert_cv_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cv_en_i |=> ($stable(carry_q) && $stable(ovf_q)));

  // R9: zero/sign hold while their enable is low
  assert_zs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !zs_en_i |=> ($stable(zero_q) && $stable(sign_q)));

endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [4:0]       func_code,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic             zero_nxt,
  output logic             sign_nxt,
  output logic             carry_nxt,
  output logic             ovf_nxt,
  output logic             zero_en,
  output logic             sign_en,
  output logic             carry_en,
  output logic             ovf_en,
  output logic             zero_q,
  output logic             sign_q,
  output logic             carry_q,
  output logic             ovf_q
);

  localparam int MSB = WIDTH - 1;

  op1_sel_e         op1_sel;
  op2_sel_e         op2_sel;
  cin_sel_e         cin_sel;
  logic             wr_w;
  logic             upd_zs_w;
  logic             upd_cv_w;
  logic [WIDTH-1:0] op1_w;
  logic [WIDTH-1:0] op2_w;
  logic             cin_w;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;
  logic             ovf_w;

  arith_decode u_decode (
    .op_valid  (op_valid),
    .func_code (func_code),
    .op1_sel   (op1_sel),
    .op2_sel   (op2_sel),
    .cin_sel   (cin_sel),
    .wr_o      (wr_w),
    .upd_zs_o  (upd_zs_w),
    .upd_cv_o  (upd_cv_w)
  );

  arith_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .op1_sel      (op1_sel),
    .op2_sel      (op2_sel),
    .cin_sel      (cin_sel),
    .a_i          (a_in),
    .b_i          (b_in),
    .carry_flag_i (carry_q),
    .op1_o        (op1_w),
    .op2_o        (op2_w),
    .cin_o        (cin_w)
  );

  arith_adder #(.WIDTH(WIDTH)) u_adder (
    .op1_i  (op1_w),
    .op2_i  (op2_w),
    .cin_i  (cin_w),
    .sum_o  (sum_w),
    .cout_o (cout_w),
    .ovf_o  (ovf_w)
  );

  assign result    = sum_w;
  assign result_we = wr_w;
  assign zero_nxt  = ~|sum_w;
  assign sign_nxt  = sum_w[MSB];
  assign carry_nxt = cout_w;
  assign ovf_nxt   = ovf_w;
  assign zero_en   = upd_zs_w;
  assign sign_en   = upd_zs_w;
  assign carry_en  = upd_cv_w;
  assign ovf_en    = upd_cv_w;

  arith_flag_file u_flags (
    .clk     (clk),
    .rst     (rst),
    .zs_en_i (upd_zs_w),
    .cv_en_i (upd_cv_w),
    .zero_d  (zero_nxt),
    .sign_d  (sign_nxt),
    .carry_d (carry_nxt),
    .ovf_d   (ovf_nxt),
    .zero_q  (zero_q),
    .sign_q  (sign_q),
    .carry_q (carry_q),
    .ovf_q   (ovf_q)
  );

  // R7: overflow only when like-signed operands give an opposite-signed sum
  assert_ovf_sign_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_nxt |-> ((op1_w[MSB] == op2_w[MSB]) && (result[MSB] != op1_w[MSB])));

  // R3: compare never writes but updates carry/overflow
  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && func_code == FN_CMP) |-> (!result_we && carry_en && zero_en));

  // R4: increment/decrement keep stored carry and overflow
  assert_incdec_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (func_code == FN_INC || func_code == FN_DEC))
      |=> (carry_q == $past(carry_q) && ovf_q == $past(ovf_q)));

  // R6: stored sign follows the presented next value when enabled
  assert_sign_latch_R6: assert property (@(posedge clk) disable iff (rst)
    sign_en |=> (sign_q == $past(sign_nxt)));

  // R9: no enable without the strobe
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!result_we && !zero_en && !sign_en && !carry_en && !ovf_en));

endmodule

// File: tb/arith_unit_tb_top.sv
`timescale 1ns/1ps
module arith_unit_tb_top;

  localparam int W    = 4;
  localparam int MOD  = 1 << W;
  localparam int MASK = MOD - 1;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic [4:0]   func_code;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic [W-1:0] result;
  logic         result_we;
  logic         zero_nxt, sign_nxt, carry_nxt, ovf_nxt;
  logic         zero_en, sign_en, carry_en, ovf_en;
  logic         zero_q, sign_q, carry_q, ovf_q;

  always #2.5 clk = ~clk;

  arith_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .func_code(func_code),
    .a_in(a_in), .b_in(b_in), .result(result), .result_we(result_we),
    .zero_nxt(zero_nxt), .sign_nxt(sign_nxt), .carry_nxt(carry_nxt), .ovf_nxt(ovf_nxt),
    .zero_en(zero_en), .sign_en(sign_en), .carry_en(carry_en), .ovf_en(ovf_en),
    .zero_q(zero_q), .sign_q(sign_q), .carry_q(carry_q), .ovf_q(ovf_q)
  );

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (code=%0d a=%0d b=%0d)",
               tag, act, exp, func_code, a_in, b_in);
    end
  endtask

  function automatic int sx(input int v);
    return (v > SMAX) ? v - MOD : v;
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      default: return "R5";
    endcase
  endfunction

  // leaves stored carry = c by a compare of 0 with 0 (carry out) or 0 with 1
  task automatic set_carry(input int c);
    @(negedge clk);
    op_valid  = 1'b1;
    func_code = 5'd2;
    a_in      = '0;
    b_in      = (c != 0) ? W'(0) : W'(1);
    @(negedge clk);
  endtask

  task automatic run_op(input int op, input int a, input int b, input int c);
    int o1, o2, ci, tot, stot, er;
    int ez, es, ec, ev;
    int wr, cv;
    int pz, ps, pc, pv;
    o1 = (op == 5 || op == 7) ? (~a & MASK) : a;
    case (op)
      0: begin o2 = b;            ci = c;     end
      1: begin o2 = ~b & MASK;    ci = 1 - c; end
      2: begin o2 = ~b & MASK;    ci = 1;     end
      3: begin o2 = 0;            ci = 1;     end
      4: begin o2 = MASK;         ci = 0;     end
      5: begin o2 = 0;            ci = 1;     end
      default: begin o2 = 0;      ci = 0;     end
    endcase
    tot  = o1 + o2 + ci;
    stot = sx(o1) + sx(o2) + ci;
    er   = tot % MOD;
    ec   = (tot >= MOD) ? 1 : 0;
    ev   = (stot > SMAX || stot < SMIN) ? 1 : 0;
    ez   = (er == 0) ? 1 : 0;
    es   = (er >> (W - 1)) & 1;
    wr   = (op == 2) ? 0 : 1;
    cv   = (op == 3 || op == 4) ? 0 : 1;

    op_valid  = 1'b1;
    func_code = 5'(op);
    a_in      = W'(a);
    b_in      = W'(b);
    #1;
    pz = zero_q; ps = sign_q; pc = carry_q; pv = ovf_q;
    chk("R9", pc, c);
    if (wr != 0) chk(op_tag(op), int'(result), er);
    chk(op_tag(op), int'(result_we), wr);
    chk("R6", int'(zero_nxt), ez);
    chk("R6", int'(sign_nxt), es);
    chk(op_tag(op), int'(zero_en & sign_en), 1);
    chk(op_tag(op), int'(carry_en), cv);
    chk(op_tag(op), int'(ovf_en), cv);
    if (cv != 0) begin
      chk("R7", int'(carry_nxt), ec);
      chk("R7", int'(ovf_nxt), ev);
    end
    @(negedge clk);
    chk("R6", int'(zero_q), ez);
    chk("R6", int'(sign_q), es);
    chk((cv != 0) ? "R7" : "R4", int'(carry_q), (cv != 0) ? ec : pc);
    chk((cv != 0) ? "R7" : "R4", int'(ovf_q),   (cv != 0) ? ev : pv);
    if (ps < 0) chk("R6", ps, 0);
    if (pz < 0) chk("R6", pz, 0);
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; func_code = '0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", int'({zero_q, sign_q, carry_q, ovf_q}), 0);
    rst = 1'b0;
    #1;
    chk("R9", int'({result_we, zero_en, sign_en, carry_en, ovf_en}), 0);

    // full sweep of defined codes, operands and stored carry
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < MOD; a++)
        for (int b = 0; b < MOD; b++)
          for (int c = 0; c < 2; c++) begin
            set_carry(c);
            run_op(op, a, b, c);
          end

    // R8: reserved codes after flags set to zero=1, carry=1
    for (int fc = 8; fc < 32; fc++) begin
      set_carry(1);
      func_code = 5'(fc);
      a_in = W'(fc % MOD);
      b_in = W'((fc * 3) % MOD);
      #1;
      chk("R8", int'({result_we, zero_en, sign_en, carry_en, ovf_en}), 0);
      @(negedge clk);
      chk("R8", int'({zero_q, sign_q, carry_q, ovf_q}), 4'b1010);
    end

    // R9: strobe low with a legal code does nothing
    set_carry(1);
    op_valid  = 1'b0;
    func_code = 5'd0;
    a_in = W'(9); b_in = W'(9);
    #1;
    chk("R9", int'({result_we, zero_en, sign_en, carry_en, ovf_en}), 0);
    @(negedge clk);
    chk("R9", int'({zero_q, sign_q, carry_q, ovf_q}), 4'b1010);

    // R9: reset mid-run overrides a valid add
    set_carry(1);
    rst = 1'b1;
    func_code = 5'd0; op_valid = 1'b1; a_in = W'(7); b_in = W'(1);
    @(negedge clk);
    chk("R9", int'({zero_q, sign_q, carry_q, ovf_q}), 0);
    rst = 1'b0; op_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule